// File: doc/BRIEF.md
# Atomic Byte-Access Modulus Register Bank

This block holds a small set of wide modulus values, 12 or 16 bits each, for counters that reload from them. An 8-bit processor bus reaches each value as two bytes, upper and lower. The whole bank shares one byte-wide staging buffer, so a wide value only ever changes in a single clock and a counter never sees half of a new value.

Software stores the upper byte first. That byte only lands in the staging buffer. The later lower-byte store moves both bytes into the register together. Reads work the other way round. Reading the lower byte returns it at once and copies the register's upper byte into the staging buffer. A following upper-byte read then returns that copy, so the two bytes always belong to the same value. Each register feeds a reloading down-counter. The counter is held at zero while its enable input is low. It pulses once at every reload.

There are three registers. Register 0 and register 1 are 12 bits wide. Register 2 is 16 bits wide and serves the receive counter. A commit of a value below 0x000F is not a valid setting, and the block flags it on a status output.

Top module: `modbank`

## Requirements
- R1: After synchronous reset, all three modulus outputs, `rd_data`, `reload_tick`, `mod_bad` and the staging buffer are zero. An upper-byte read straight after reset returns 0x00.
- R2: A store to an upper-byte address loads only the staging buffer. No modulus output changes.
- R3: A store to a lower-byte address commits {staging buffer, store data} into that register in one clock edge. The new value is on `mod_q` in the cycle after the store.
- R4: A lower-byte read returns the register's low byte. It also copies the register's current upper byte into the staging buffer, replacing any byte parked there.
- R5: The staging buffer is shared by all registers. After two upper-byte stores to different registers, a lower-byte store commits the byte from the second upper-byte store.
- R6: Registers 0 and 1 keep only bits 3:0 of the upper byte. Their bits 7:4 read back as zero, both on `mod_q` and through upper-byte reads.
- R7: Address map: register i has its upper byte at 0x0B+2i and its lower byte at 0x0C+2i. The 16-bit receive register therefore sits at 0x0F (upper) and 0x10 (lower). Any other address reads as 0x00 and leaves the staging buffer and all registers unchanged.
- R8: An upper-byte read returns the staging buffer, masked to the register's implemented bits.
- R9: While `cnt_en[i]` is low, counter i stays at zero and `reload_tick[i]` stays low.
- R10: While enabled with modulus M, counter i reloads every M+1 cycles, and `reload_tick[i]` is high for one cycle at each reload.
- R11: A modulus committed while a count is in progress takes effect at the next reload. The current period completes with the old value.
- R12: `mod_bad[i]` pulses high for one cycle, in the cycle after a commit to register i of a value below 0x000F. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address for the bus access |
| wr_en | input | 1 | Store strobe (takes priority over `rd_en`) |
| wr_data | input | 8 | Store data |
| rd_en | input | 1 | Load strobe |
| rd_data | output | 8 | Load data, registered, valid in the cycle after `rd_en` |
| cnt_en | input | 3 | Per-register counter enable; low holds the counter in reset |
| mod_q | output | 48 | Committed modulus values, register i at bits 16i+15:16i, zero-extended |
| reload_tick | output | 3 | One-cycle pulse at each counter reload |
| mod_bad | output | 3 | One-cycle flag after a commit of a value below 0x000F |

## Verification
The assertions check the following on every cycle:
- an upper-byte store never moves `mod_q`;
- a register holds its value unless it is committed;
- a lower-byte read leaves the live upper byte in the staging buffer;
- unmapped accesses leave the buffer alone;
- a disabled counter stays idle;
- every reload tick comes from a zero count and reloads the modulus that was presented to the counter.

Only the bench scenarios can show the effects that depend on order:
- the second of two upper-byte stores wins;
- an upper-byte read after a lower-byte read returns the captured byte, not the byte parked earlier;
- a new modulus changes the tick spacing only one period later.

// File: rtl/modbank_pkg.sv
package modbank_pkg;

    localparam int NREG      = 3;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int MOD_MAX_W = 16;
    localparam int NARROW_W  = 12;
    localparam int IDX_W     = (NREG > 1) ? $clog2(NREG) : 1;

    localparam logic [ADDR_W-1:0]    BANK_BASE = 8'h0B;
    localparam logic [MOD_MAX_W-1:0] MIN_MOD   = 16'h000F;

    typedef logic [DATA_W-1:0]    byte_t;
    typedef logic [MOD_MAX_W-1:0] mod_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_HI   = 2'd1,
        ACC_LO   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic             hit;
        logic             lo;
        logic [IDX_W-1:0] idx;
    } addr_dec_t;

    // Highest register index is the full-width receive modulus.
    function automatic int reg_width(int i);
        return (i == NREG - 1) ? MOD_MAX_W : NARROW_W;
    endfunction

    function automatic byte_t hi_mask_of(logic [IDX_W-1:0] idx);
        int w;
        w = reg_width(int'(idx));
        return byte_t'((1 << (w - DATA_W)) - 1);
    endfunction

    function automatic addr_dec_t decode(logic [ADDR_W-1:0] a);
        addr_dec_t        d;
        logic [ADDR_W-1:0] off;
        d   = '0;
        off = a - BANK_BASE;
        if (a >= BANK_BASE && off < ADDR_W'(2 * NREG)) begin
            d.hit = 1'b1;
            d.lo  = off[0];
            d.idx = off[IDX_W:1];
        end
        return d;
    endfunction

    function automatic mod_t assemble(byte_t hi, byte_t lo, int w);
        mod_t m;
        m = {hi, lo};
        return m & mod_t'((1 << w) - 1);
    endfunction

endpackage

// File: rtl/modbank_tmpbuf.sv
module modbank_tmpbuf
    import modbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_wr,
    input  byte_t wr_byte,
    input  logic  load_snap,
    input  byte_t snap_byte,
    output byte_t tmp_q
);

    // A parked upper-byte store wins over a snapshot in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            tmp_q <= '0;
        end else if (load_wr) begin
            tmp_q <= wr_byte;
        end else if (load_snap) begin
            tmp_q <= snap_byte;
        end
    end

    assert_snap_loads_buffer_R4: assert property (@(posedge clk) disable iff (rst)
        (load_snap && !load_wr) |=> (tmp_q == $past(snap_byte)));

endmodule

// File: rtl/modbank_reg.sv
module modbank_reg
    import modbank_pkg::*;
#(
    parameter int W = MOD_MAX_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  commit,
    input  byte_t hi_byte,
    input  byte_t lo_byte,
    output mod_t  q_ext,
    output logic  bad_pulse
);

    logic [W-1:0] q;
    mod_t         cand;

    assign cand  = assemble(hi_byte, lo_byte, W);
    assign q_ext = MOD_MAX_W'(q);

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            bad_pulse <= 1'b0;
        end else begin
            bad_pulse <= 1'b0;
            if (commit) begin
                q         <= cand[W-1:0];
                bad_pulse <= (cand < MIN_MOD);
            end
        end
    end

    assert_hold_without_commit_R3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(q));

    assert_bad_only_after_commit_R12: assert property (@(posedge clk) disable iff (rst)
        bad_pulse |-> $past(commit));

endmodule

// File: rtl/modbank_cnt.sv
module modbank_cnt
    import modbank_pkg::*;
#(
    parameter int W = MOD_MAX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] modulus,
    output logic         tick
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= modulus;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end

    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0 && !tick));

    assert_reload_takes_modulus_R10: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt == $past(modulus)));

    assert_reload_only_at_zero_R11: assert property (@(posedge clk) disable iff (rst)
        tick |-> ($past(cnt) == '0));

endmodule

// File: rtl/modbank.sv
module modbank
    import modbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      rd_en,
    output logic [DATA_W-1:0]         rd_data,
    input  logic [NREG-1:0]           cnt_en,
    output logic [NREG*MOD_MAX_W-1:0] mod_q,
    output logic [NREG-1:0]           reload_tick,
    output logic [NREG-1:0]           mod_bad
);

    addr_dec_t dec;
    acc_kind_e wr_kind, rd_kind;
    byte_t     tmp;
    mod_t      mods [NREG];
    mod_t      live;
    logic      wr_hi, wr_lo, rd_lo, rd_hi;

    assign dec = decode(addr);

    always_comb begin
        wr_kind = ACC_NONE;
        rd_kind = ACC_NONE;
        if (dec.hit) begin
            if (wr_en)      wr_kind = dec.lo ? ACC_LO : ACC_HI;
            else if (rd_en) rd_kind = dec.lo ? ACC_LO : ACC_HI;
        end
    end

    assign wr_hi = (wr_kind == ACC_HI);
    assign wr_lo = (wr_kind == ACC_LO);
    assign rd_hi = (rd_kind == ACC_HI);
    assign rd_lo = (rd_kind == ACC_LO);

    always_comb begin
        live = '0;
        for (int i = 0; i < NREG; i++) begin
            if (dec.idx == IDX_W'(i)) live = mods[i];
        end
    end

    modbank_tmpbuf u_tmp (
        .clk       (clk),
        .rst       (rst),
        .load_wr   (wr_hi),
        .wr_byte   (wr_data),
        .load_snap (rd_lo),
        .snap_byte (live[MOD_MAX_W-1:DATA_W]),
        .tmp_q     (tmp)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int WI = reg_width(i);
        logic commit_i;

        assign commit_i = wr_lo && (dec.idx == IDX_W'(i));

        modbank_reg #(.W(WI)) u_reg (
            .clk       (clk),
            .rst       (rst),
            .commit    (commit_i),
            .hi_byte   (tmp),
            .lo_byte   (wr_data),
            .q_ext     (mods[i]),
            .bad_pulse (mod_bad[i])
        );

        modbank_cnt #(.W(WI)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .en      (cnt_en[i]),
            .modulus (mods[i][WI-1:0]),
            .tick    (reload_tick[i])
        );

        assign mod_q[i*MOD_MAX_W +: MOD_MAX_W] = mods[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en && !wr_en) begin
            unique case (rd_kind)
                ACC_LO:  rd_data <= live[DATA_W-1:0];
                ACC_HI:  rd_data <= tmp & hi_mask_of(dec.idx);
                default: rd_data <= '0;
            endcase
        end
    end

    assert_hi_store_keeps_outputs_R2: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> $stable(mod_q));

    assert_unmapped_keeps_buffer_R7: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |=> $stable(tmp));

    assert_hi_read_masked_R6: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> ((rd_data & ~$past(hi_mask_of(dec.idx))) == '0));

    assert_lo_read_snapshots_R4: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> (tmp == $past(live[MOD_MAX_W-1:DATA_W])));

endmodule

// File: tb/modbank_bench.sv
module modbank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [2:0]  cnt_en = '0;
    logic [47:0] mod_q;
    logic [2:0]  reload_tick;
    logic [2:0]  mod_bad;

    always #5 clk = ~clk;

    modbank u_modbank (
        .clk         (clk),
        .rst         (rst),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .cnt_en      (cnt_en),
        .mod_q       (mod_q),
        .reload_tick (reload_tick),
        .mod_bad     (mod_bad)
    );

    int          vectors  = 0;
    int          miscomp  = 0;
    bit          done     = 1'b0;
    int unsigned m_reg [3];
    int unsigned m_tmp    = 0;
    int          nt       = 0;
    int          since    = 0;
    int          gaps [8];

    function automatic int width_of(int i);
        return (i == 2) ? 16 : 12;
    endfunction

    // Returns -1 for unmapped, else idx*2 + (1 for lower byte).
    function automatic int map_addr(logic [7:0] a);
        if (a < 8'h0B || a > 8'h10) return -1;
        return int'(a) - 8'h0B;
    endfunction

    function automatic int unsigned exp_mod(int i, int unsigned hi, int unsigned lo);
        return ((hi << 8) | lo) & ((1 << width_of(i)) - 1);
    endfunction

    task automatic chk(string req, int unsigned act, int unsigned exp);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_mods(string req);
        for (int i = 0; i < 3; i++) chk(req, mod_q[i*16 +: 16], m_reg[i]);
    endtask

    task automatic bus_wr(logic [7:0] a, logic [7:0] d);
        int code;
        int unsigned exp_bad;
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        code = map_addr(a);
        exp_bad = 0;
        if (code >= 0) begin
            if (code % 2 == 1) begin
                m_reg[code/2] = exp_mod(code/2, m_tmp, d);
                if (m_reg[code/2] < 16'h000F) exp_bad = 1 << (code/2);
            end else begin
                m_tmp = d;
            end
        end
        chk("R12", mod_bad, exp_bad);
        chk_mods((code >= 0 && code % 2 == 1) ? "R3" : "R2");
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [7:0] v);
        int code;
        int unsigned exp;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
        code = map_addr(a);
        if (code < 0) begin
            exp = 0;
            chk("R7", v, exp);
        end else if (code % 2 == 1) begin
            exp = m_reg[code/2] & 8'hFF;
            m_tmp = m_reg[code/2] >> 8;
            chk("R4", v, exp);
        end else begin
            exp = m_tmp & ((code/2 == 2) ? 8'hFF : 8'h0F);
            chk("R8", v, exp);
        end
    endtask

    always @(negedge clk) begin
        since++;
        if (reload_tick[0]) begin
            if (nt < 8) gaps[nt] = since;
            nt++;
            since = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog R10: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n0;
        for (int i = 0; i < 3; i++) m_reg[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", mod_q, 0);
        chk("R1", rd_data, 0);
        chk("R1", reload_tick, 0);
        chk("R1", mod_bad, 0);
        bus_rd(8'h0F, v);
        chk("R1", v, 8'h00);

        // R6: narrow register drops upper nibble
        bus_wr(8'h0B, 8'hAB);
        chk("R2", mod_q[15:0], 16'h0000);
        bus_wr(8'h0C, 8'hCD);
        chk("R6", mod_q[15:0], 16'h0BCD);
        bus_rd(8'h0C, v);
        bus_rd(8'h0B, v);
        chk("R6", v, 8'h0B);

        // R5: second parked byte wins
        bus_wr(8'h0B, 8'h05);
        bus_wr(8'h0D, 8'h09);
        bus_wr(8'h0C, 8'h33);
        chk("R5", mod_q[15:0], 16'h0933);

        // R4: lower read replaces a parked byte
        bus_wr(8'h0D, 8'h02);
        bus_wr(8'h0E, 8'h44);
        bus_wr(8'h0F, 8'h77);
        bus_rd(8'h0E, v);
        chk("R4", v, 8'h44);
        bus_rd(8'h0F, v);
        chk("R4", v, 8'h02);

        // R7: unmapped accesses leave the buffer alone
        bus_wr(8'h0F, 8'h5A);
        bus_rd(8'h20, v);
        bus_wr(8'h30, 8'h11);
        bus_rd(8'h0F, v);
        chk("R7", v, 8'h5A);

        // R12: flag at boundary on the receive register
        bus_wr(8'h0F, 8'h00);
        bus_wr(8'h10, 8'h0E);
        bus_wr(8'h0F, 8'h00);
        bus_wr(8'h10, 8'h0F);
        chk("R12", mod_q[47:32], 16'h000F);

        // Random mix
        void'($urandom(32'h00C0FFEE));
        for (int k = 0; k < 400; k++) begin
            logic [7:0] a;
            a = 8'h09 + 8'($urandom % 11);
            if ($urandom % 2 == 0) bus_wr(a, 8'($urandom));
            else bus_rd(a, v);
        end
        chk("R9", nt, 0);

        // R10/R11: counter period and deferred modulus
        bus_wr(8'h0B, 8'h00);
        bus_wr(8'h0C, 8'h10);
        @(negedge clk);
        cnt_en[0] = 1'b1;
        wait (nt == 2);
        chk("R10", gaps[1], 17);
        bus_wr(8'h0B, 8'h00);
        bus_wr(8'h0C, 8'h14);
        wait (nt == 4);
        chk("R11", gaps[2], 17);
        chk("R11", gaps[3], 21);

        // R9: disable holds the counter quiet
        @(negedge clk);
        cnt_en[0] = 1'b0;
        @(negedge clk);
        n0 = nt;
        repeat (40) @(negedge clk);
        chk("R9", nt, n0);
        chk("R9", reload_tick, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule